// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every data beat in a memory burst. A start strobe captures a starting column together with the burst configuration: a length code, a linear or interleaved ordering, and a flag that makes every write burst a single beat. On the cycles that follow, the block presents one column per cycle with a valid flag. On the final beat of a fixed-length burst it also raises a last flag.

Linear bursts count up within an aligned block of 2, 4 or 8 columns and wrap inside it. Interleaved bursts XOR the beat index into the low bits of the start column. A full-page burst steps through every column of the 512-column page, wraps modulo 512, and ends only on a stop request. A memory controller uses the column stream to drive the column address of each access, and uses the last flag to schedule its next command.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o and last_o are low until the first start strobe is sampled.
- R2: The clock edge that samples start_i high latches col_i and the configuration. From the next cycle, valid_o is high and col_o equals col_i on the first beat. One beat follows per cycle.
- R3: The length code bl_i selects the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 give 1 beat.
- R4: With ilv_i low and a length of 2^k (k = 1..3), beat n has column bits above k-1 equal to the start column. Its low k bits equal (start low bits + n) mod 2^k.
- R5: With ilv_i high and a length of 2^k, beat n has the column equal to the start column with its low k bits XORed with n.
- R6: A full-page burst ignores ilv_i. It presents (start + n) mod 512, never raises last_o, and continues until stopped or restarted.
- R7: last_o is high only on the final beat of a fixed-length burst. valid_o is low in the cycle after that beat unless a new start was sampled.
- R8: A stop_i sampled high with start_i low ends the burst, and valid_o is low in the next cycle. When start_i and stop_i are high together, the start takes effect.
- R9: With brsw_i high, a burst started with wr_i high lasts exactly one beat whatever bl_i holds. A read burst keeps its programmed length.
- R10: A start sampled during an active burst abandons the old burst. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the values on col_i and the mode inputs |
| col_i | input | 9 | Start column |
| wr_i | input | 1 | High for a write burst |
| stop_i | input | 1 | End the active burst |
| bl_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Interleaved ordering when high, linear when low |
| brsw_i | input | 1 | Force write bursts to a single beat |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its defaults: a 9-bit column and a 3-bit length code whose longest fixed burst is 8 beats. With these values a full-page run can cross the 0x1FF-to-0x000 boundary within a few cycles. The 8-beat bursts place the wrap inside an aligned group above bit 2 of the column, so the bench can show that the upper bits stay fixed. The same width makes the reserved codes 4 to 6 reachable, so the bench can confirm they fall back to a single beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned COL_W   = 9;
  localparam int unsigned BL_W    = 3;
  localparam int unsigned MAX_LOG = 3;
  localparam logic [BL_W-1:0] BL_PAGE = '1;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
  parameter int unsigned COL_W   = bcs_pkg::COL_W,
  parameter int unsigned BL_W    = bcs_pkg::BL_W,
  parameter int unsigned MAX_LOG = bcs_pkg::MAX_LOG
) (
  input  logic [BL_W-1:0]  bl_i,
  input  logic             wr_i,
  input  logic             brsw_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  localparam logic [BL_W-1:0] PAGE_CODE = '1;

  logic single;
  assign single = wr_i & brsw_i;

  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    if (!single) begin
      if (bl_i == PAGE_CODE) begin
        page_o = 1'b1;
        mask_o = '1;
      end else begin
        for (int unsigned k = 1; k <= MAX_LOG; k++) begin
          if (bl_i == BL_W'(k)) mask_o = (COL_W'(1) << k) - COL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             page_i,
  input  logic [COL_W-1:0] last_idx_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;

  assign last_o   = active_q & ~page_i & (beat_q == last_idx_i);
  assign active_o = active_q;
  assign beat_o   = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (stop_i || last_o) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (active_q) begin
      beat_q <= beat_q + COL_W'(1);  // page wraps modulo 2^COL_W
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum, lin, ilv;

  assign sum = base_i + beat_i;
  assign lin = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv = base_i ^ (beat_i & mask_i);
  assign col_o = ilv_i ? ilv : lin;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int unsigned COL_W   = bcs_pkg::COL_W,
  parameter int unsigned BL_W    = bcs_pkg::BL_W,
  parameter int unsigned MAX_LOG = bcs_pkg::MAX_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             wr_i,
  input  logic             stop_i,
  input  logic [BL_W-1:0]  bl_i,
  input  logic             ilv_i,
  input  logic             brsw_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] mask_d, mask_q, base_q, beat;
  logic             page_d, page_q, ilv_q, active, last;

  bcs_len_decode #(.COL_W(COL_W), .BL_W(BL_W), .MAX_LOG(MAX_LOG)) i_dec (
    .bl_i   (bl_i),
    .wr_i   (wr_i),
    .brsw_i (brsw_i),
    .mask_o (mask_d),
    .page_o (page_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= col_i;
      mask_q <= mask_d;
      page_q <= page_d;
      ilv_q  <= ilv_i & ~page_d;  // full page always linear
    end
  end

  bcs_beat_ctr #(.COL_W(COL_W)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .page_i     (page_q),
    .last_idx_i (mask_q),
    .active_o   (active),
    .beat_o     (beat),
    .last_o     (last)
  );

  bcs_col_gen #(.COL_W(COL_W)) i_col (
    .base_i (base_q),
    .beat_i (beat),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign valid_o = active;
  assign last_o  = last;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             page_q
);
  a_r7_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r7_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && !start_i) |=> !valid_o);

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !valid_o);

  a_r10_start_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(col_i)));

  a_r6_page_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q) |-> !last_o);

  a_r6_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q && !start_i && !stop_i) |=> (valid_o && col_o == $past(col_o) + COL_W'(1)));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) i_bcs_checker (
  .clk_i, .rst_ni, .start_i, .stop_i, .col_i, .col_o, .valid_o, .last_o, .page_q
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       start = 0, wr = 0, stop = 0, ilv = 0, brsw = 0;
  logic [8:0] col_in = '0;
  logic [2:0] bl = '0;
  logic [8:0] col_out;
  logic       valid, last;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .col_i(col_in), .wr_i(wr),
    .stop_i(stop), .bl_i(bl), .ilv_i(ilv), .brsw_i(brsw),
    .col_o(col_out), .valid_o(valid), .last_o(last)
  );

  typedef struct packed {
    logic [8:0]      col;
    logic            w;
    logic [2:0]      code;
    logic            il;
    logic            bs;
    logic [3:0]      n;
    logic [0:7][8:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{9'h005, 1'b0, 3'd2, 1'b0, 1'b0, 4'd4, {9'h005, 9'h006, 9'h007, 9'h004, 9'h0, 9'h0, 9'h0, 9'h0}}, // R4
    '{9'h005, 1'b0, 3'd2, 1'b1, 1'b0, 4'd4, {9'h005, 9'h004, 9'h007, 9'h006, 9'h0, 9'h0, 9'h0, 9'h0}}, // R5
    '{9'h0FE, 1'b0, 3'd3, 1'b0, 1'b0, 4'd8, {9'h0FE, 9'h0FF, 9'h0F8, 9'h0F9, 9'h0FA, 9'h0FB, 9'h0FC, 9'h0FD}}, // R4
    '{9'h0FE, 1'b0, 3'd3, 1'b1, 1'b0, 4'd8, {9'h0FE, 9'h0FF, 9'h0FC, 9'h0FD, 9'h0FA, 9'h0FB, 9'h0F8, 9'h0F9}}, // R5
    '{9'h123, 1'b0, 3'd1, 1'b0, 1'b0, 4'd2, {9'h123, 9'h122, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}, // R3
    '{9'h123, 1'b0, 3'd0, 1'b0, 1'b0, 4'd1, {9'h123, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}, // R3
    '{9'h040, 1'b1, 3'd3, 1'b0, 1'b1, 4'd1, {9'h040, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}, // R9
    '{9'h041, 1'b0, 3'd1, 1'b1, 1'b1, 4'd2, {9'h041, 9'h040, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}, // R9
    '{9'h1FF, 1'b1, 3'd2, 1'b0, 1'b0, 4'd4, {9'h1FF, 9'h1FC, 9'h1FD, 9'h1FE, 9'h0, 9'h0, 9'h0, 9'h0}}, // R9
    '{9'h010, 1'b0, 3'd5, 1'b0, 1'b0, 4'd1, {9'h010, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0}}  // R3
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [8:0] c, input logic w, input logic [2:0] code,
                             input logic il, input logic bs);
    @(negedge clk);
    start = 1; col_in = c; wr = w; bl = code; ilv = il; brsw = bs;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid, 0);
    chk("R1 last", last, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 valid idle", valid, 0);

    // table walk, R2 R3 R4 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      pulse_start(VEC[v].col, VEC[v].w, VEC[v].code, VEC[v].il, VEC[v].bs);
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        chk("R2 valid", valid, 1);
        chk("R4/R5 col", col_out, VEC[v].exp[i]);
        chk("R7 last", last, (i == int'(VEC[v].n) - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R7 end", valid, 0);
      @(negedge clk);
    end

    // R6 full page, interleave bit ignored, wraps past 0x1FF
    pulse_start(9'h1FD, 1'b0, 3'd7, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      chk("R6 valid", valid, 1);
      chk("R6 col", col_out, (9'h1FD + i) & 9'h1FF);
      chk("R6 no last", last, 0);
      @(negedge clk);
    end
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 page stop", valid, 0);

    // R6 page write with brsw low keeps page length
    pulse_start(9'h000, 1'b1, 3'd7, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R6 long run", valid, 1);
    chk("R6 long col", col_out, 9'h014);
    stop = 1;
    @(negedge clk);
    stop = 0;

    // R8 stop mid fixed burst
    pulse_start(9'h080, 1'b0, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 mid col", col_out, 9'h081);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 stop", valid, 0);
    @(negedge clk);
    chk("R8 stays off", valid, 0);

    // R10 restart during burst
    pulse_start(9'h000, 1'b0, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    pulse_start(9'h100, 1'b0, 3'd1, 1'b0, 1'b0);
    chk("R10 col0", col_out, 9'h100);
    chk("R10 last0", last, 0);
    @(negedge clk);
    chk("R10 col1", col_out, 9'h101);
    chk("R10 last1", last, 1);
    @(negedge clk);
    chk("R10 end", valid, 0);

    // R8 start wins over simultaneous stop
    pulse_start(9'h020, 1'b0, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    start = 1; stop = 1; col_in = 9'h033; bl = 3'd0;
    @(negedge clk);
    start = 0; stop = 0;
    chk("R8 start wins valid", valid, 1);
    chk("R8 start wins col", col_out, 9'h033);
    chk("R8 start wins last", last, 1);
    @(negedge clk);
    chk("R8 start wins end", valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule